// File: doc/BRIEF.md
# Physical Region Pointer Walker

This block converts one host transfer descriptor into a sequence of contiguous memory segments. A descriptor carries a byte count and two 64-bit page pointers. The first pointer may start anywhere inside a page, so the first segment runs only up to the next page boundary. What follows depends on how much data is left. If one page or less remains, the second pointer names that page directly. If more remains, the second pointer names a page-sized table of 8-byte entries, and the block fetches those entries one at a time through a memory read port.

When a table runs out while more than a page of data is still left, its final slot links to a further table. Every pointer taken from a table, whether it names data or a further table, is checked. If any check fails, the walk stops with an error.

Segments leave on a valid/ready stream. Each descriptor ends with a one-cycle completion pulse that carries an error flag. The data payload itself is moved elsewhere.

Top module: `prp_walker`

## Requirements
- R1: The page size is 2^(12+req_mps) bytes, with req_mps taken as a 2-bit value at request time. A table page holds page_size/8 entries, and the last slot has index page_size/8-1.
- R2: The first segment has address req_ptr1 and length min(req_len, page_size - (req_ptr1 mod page_size)).
- R3: A request with req_ptr1 equal to zero ends with done and err and emits no segment. A request with nonzero req_ptr1 and zero req_len ends with done, without err and without any segment.
- R4: If bytes remain after the first segment and req_ptr2 is zero, the walk ends with err after the first segment.
- R5: If the remaining length after the first segment is at most one page, req_ptr2 must be page-aligned. It is then emitted as one segment of the remaining length; otherwise the walk ends with err.
- R6: If more than one page remains, table entry i is read from address base + 8*i. rsp_data bits 7:0 hold the byte at the lowest address (little-endian). Each entry gives one segment of length min(remaining, page_size).
- R7: When the entry at the last slot index is returned and more than one page remains, that entry is taken as the base of the next table and the index restarts at 0. With one page or less remaining, the entry in the last slot is data.
- R8: A table entry that is zero or not page-aligned ends the walk with err. After that entry no further segment is emitted and no further read is issued.
- R9: seg_addr and seg_len hold steady while seg_valid is high and seg_ready is low. rd_addr holds steady while rd_valid is high and rd_ready is low. A new request is accepted only while req_ready is high.
- R10: done is high for exactly one cycle per request. err is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_len | input | 32 | Transfer byte count |
| req_ptr1 | input | 64 | First page pointer (any byte offset) |
| req_ptr2 | input | 64 | Second pointer: data page or table base |
| req_mps | input | 2 | Page size exponent above 4 KiB |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment consumer ready |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | 32 | Segment byte count |
| rd_valid | output | 1 | Table entry read request |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | 64 | Table entry address |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Table entry, little-endian |
| done | output | 1 | One-cycle end of request |
| err | output | 1 | Invalid field, valid with done |

## Verification
Two decisions fall on the same returned entry when the table index is at its last slot: whether the entry is a link to a new table or the final data page. The bench provokes this with two transfer sizes. In the first, exactly one page remains at the last slot, so the entry must come out as a data segment. In the second, two pages remain, so the entry must be followed as a link and the next read must target the linked table's slot 0. The bench memory returns, for every slot, a value derived from that slot's address. The emitted segment addresses therefore show which slots were read and how each entry was treated. A misaligned or zero link is also exercised, to confirm that link entries are checked as strictly as data entries.

// File: rtl/prp_pkg.sv
package prp_pkg;
    parameter int unsigned PRP_ADDR_W = 64;
    parameter int unsigned PRP_LEN_W  = 32;
    parameter int unsigned PRP_MPS_W  = 2;
    parameter int unsigned PRP_BASE_SHIFT = 12;
    localparam int unsigned PRP_MAX_SHIFT = PRP_BASE_SHIFT + (1 << PRP_MPS_W) - 1;
    localparam int unsigned PRP_IDX_W = PRP_MAX_SHIFT - 3;

    typedef enum logic [2:0] {
        W_IDLE, W_START, W_FIRST, W_FETCH, W_WAIT, W_EMIT, W_DONE
    } walk_st_t;

    typedef struct packed {
        logic [PRP_ADDR_W-1:0] addr;
        logic [PRP_LEN_W-1:0]  len;
    } seg_t;

    function automatic logic [PRP_LEN_W-1:0] len_min(
        input logic [PRP_LEN_W-1:0] a, input logic [PRP_LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/prp_geom.sv
module prp_geom
    import prp_pkg::*;
#(
    parameter int unsigned ADDR_W = PRP_ADDR_W,
    parameter int unsigned LEN_W  = PRP_LEN_W,
    parameter int unsigned MPS_W  = PRP_MPS_W,
    parameter int unsigned IDX_W  = PRP_IDX_W
) (
    input  logic [MPS_W-1:0]  mps,
    output logic [LEN_W-1:0]  page_size,
    output logic [ADDR_W-1:0] page_mask,
    output logic [IDX_W-1:0]  last_idx
);
    logic [LEN_W-1:0] slots_m1;

    always_comb begin
        page_size = LEN_W'(1) << (PRP_BASE_SHIFT + 32'(mps));
        page_mask = ADDR_W'(page_size) - ADDR_W'(1);
        slots_m1  = (page_size >> 3) - LEN_W'(1);
        last_idx  = slots_m1[IDX_W-1:0];
    end
endmodule

// File: rtl/prp_ptr_chk.sv
module prp_ptr_chk
    import prp_pkg::*;
#(
    parameter int unsigned ADDR_W = PRP_ADDR_W
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] page_mask,
    output logic              ok
);
    assign ok = (ptr != '0) && ((ptr & page_mask) == '0);
endmodule

// File: rtl/prp_walker.sv
module prp_walker
    import prp_pkg::*;
#(
    parameter int unsigned ADDR_W = PRP_ADDR_W,
    parameter int unsigned LEN_W  = PRP_LEN_W,
    parameter int unsigned MPS_W  = PRP_MPS_W,
    localparam int unsigned IDX_W = PRP_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] req_ptr1,
    input  logic [ADDR_W-1:0] req_ptr2,
    input  logic [MPS_W-1:0]  req_mps,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_data,
    output logic              done,
    output logic              err
);
    walk_st_t          st;
    seg_t              seg_r;
    logic [LEN_W-1:0]  rem_r;
    logic [ADDR_W-1:0] ptr2_r;
    logic [ADDR_W-1:0] tbl_base;
    logic [IDX_W-1:0]  idx_r;
    logic [MPS_W-1:0]  mps_r;
    logic              err_r;

    logic [LEN_W-1:0]  page_size;
    logic [ADDR_W-1:0] page_mask;
    logic [IDX_W-1:0]  last_idx;
    logic              ptr2_ok, ent_ok;
    logic [LEN_W-1:0]  first_off, first_len;

    prp_geom #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W), .IDX_W(IDX_W)) u_geom (
        .mps(mps_r), .page_size(page_size), .page_mask(page_mask), .last_idx(last_idx)
    );

    prp_ptr_chk #(.ADDR_W(ADDR_W)) u_chk_p2 (
        .ptr(ptr2_r), .page_mask(page_mask), .ok(ptr2_ok)
    );

    prp_ptr_chk #(.ADDR_W(ADDR_W)) u_chk_ent (
        .ptr(rsp_data), .page_mask(page_mask), .ok(ent_ok)
    );

    assign first_off = seg_r.addr[LEN_W-1:0] & page_mask[LEN_W-1:0];
    assign first_len = len_min(rem_r, page_size - first_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= W_IDLE;
            seg_r    <= '0;
            rem_r    <= '0;
            ptr2_r   <= '0;
            tbl_base <= '0;
            idx_r    <= '0;
            mps_r    <= '0;
            err_r    <= 1'b0;
        end else begin
            case (st)
                W_IDLE: if (req_valid) begin
                    seg_r.addr <= req_ptr1;
                    rem_r      <= req_len;
                    ptr2_r     <= req_ptr2;
                    mps_r      <= req_mps;
                    err_r      <= 1'b0;
                    st         <= W_START;
                end
                W_START: begin
                    if (seg_r.addr == '0) begin
                        err_r <= 1'b1;
                        st    <= W_DONE;
                    end else if (rem_r == '0) begin
                        st <= W_DONE;
                    end else begin
                        seg_r.len <= first_len;
                        rem_r     <= rem_r - first_len;
                        st        <= W_FIRST;
                    end
                end
                W_FIRST: if (seg_ready) begin
                    if (rem_r == '0) begin
                        st <= W_DONE;
                    end else if (rem_r <= page_size) begin
                        if (ptr2_ok) begin
                            seg_r.addr <= ptr2_r;
                            seg_r.len  <= rem_r;
                            st         <= W_EMIT;
                        end else begin
                            err_r <= 1'b1;
                            st    <= W_DONE;
                        end
                    end else if (ptr2_r == '0) begin
                        err_r <= 1'b1;
                        st    <= W_DONE;
                    end else begin
                        tbl_base <= ptr2_r;
                        idx_r    <= '0;
                        st       <= W_FETCH;
                    end
                end
                W_FETCH: if (rd_ready) st <= W_WAIT;
                W_WAIT: if (rsp_valid) begin
                    if (!ent_ok) begin
                        err_r <= 1'b1;
                        st    <= W_DONE;
                    end else if (idx_r == last_idx && rem_r > page_size) begin
                        tbl_base <= rsp_data;
                        idx_r    <= '0;
                        st       <= W_FETCH;
                    end else begin
                        seg_r.addr <= rsp_data;
                        seg_r.len  <= len_min(rem_r, page_size);
                        st         <= W_EMIT;
                    end
                end
                W_EMIT: if (seg_ready) begin
                    rem_r <= rem_r - seg_r.len;
                    idx_r <= idx_r + IDX_W'(1);
                    st    <= (rem_r == seg_r.len) ? W_DONE : W_FETCH;
                end
                W_DONE: st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end

    assign req_ready = (st == W_IDLE);
    assign seg_valid = (st == W_FIRST) || (st == W_EMIT);
    assign seg_addr  = seg_r.addr;
    assign seg_len   = seg_r.len;
    assign rd_valid  = (st == W_FETCH);
    assign rd_addr   = tbl_base + ADDR_W'({idx_r, 3'b000});
    assign done      = (st == W_DONE);
    assign err       = done && err_r;

    p_seg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    p_seg_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_len != '0) && (seg_len <= page_size));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_later_seg_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        (st == W_EMIT) |-> ((seg_addr & page_mask) == '0) && (seg_addr != '0));

    p_page_pow2_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(page_size) == 1);

    p_quiet_on_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !seg_valid && !rd_valid);
endmodule

// File: tb/prp_walker_test.sv
`timescale 1ns/1ps
module prp_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_len = '0;
    logic [63:0] req_ptr1 = '0, req_ptr2 = '0;
    logic [1:0]  req_mps = '0;
    logic        seg_valid, seg_ready = 1'b1;
    logic [63:0] seg_addr;
    logic [31:0] seg_len;
    logic        rd_valid, rd_ready = 1'b1;
    logic [63:0] rd_addr;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        done, err;

    always #2.5 clk = ~clk;

    prp_walker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_len(req_len), .req_ptr1(req_ptr1), .req_ptr2(req_ptr2), .req_mps(req_mps),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .err(err)
    );

    int total = 0, bad = 0, cyc = 0;
    int seg_n = 0, mism = 0, rd_n = 0, done_n = 0, exp_n = 0;
    logic err_seen = 1'b0, bp = 1'b0, pend = 1'b0;
    logic [63:0] pend_a = '0;
    logic [63:0] link_at = 64'h1, link_to = '0, bad_at = 64'h1, bad_val = '0;
    logic [63:0] exp_a [0:1023];
    logic [31:0] exp_l [0:1023];

    function automatic logic [63:0] mem(input logic [63:0] a);
        if (a == link_at) return link_to;
        if (a == bad_at) return bad_val;
        return a << 12;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic add(input logic [63:0] a, input logic [31:0] l);
        exp_a[exp_n] = a;
        exp_l[exp_n] = l;
        exp_n++;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (seg_valid && seg_ready) begin
                if (!(seg_n < exp_n && seg_addr == exp_a[seg_n] && seg_len == exp_l[seg_n])) begin
                    mism++;
                    if (mism == 1)
                        $display("mismatch at seg %0d addr=%0h len=%0h", seg_n, seg_addr, seg_len);
                end
                seg_n++;
            end
            if (done) begin
                done_n++;
                err_seen = err;
            end
            seg_ready = bp ? ~seg_ready : 1'b1;
            rsp_valid = pend;
            rsp_data  = mem(pend_a);
            pend      = rd_valid && rd_ready;
            pend_a    = rd_addr;
            if (pend) rd_n++;
        end
    end

    task automatic run(input logic [63:0] p1, input logic [63:0] p2,
                       input logic [31:0] len, input logic [1:0] mps);
        int w;
        @(negedge clk);
        seg_n = 0; mism = 0; rd_n = 0; done_n = 0; err_seen = 1'b0;
        req_ptr1 = p1; req_ptr2 = p2; req_len = len; req_mps = mps;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (done_n == 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        chk("R10 done count", 64'(done_n), 64'd1);
    endtask

    task automatic reset_model();
        link_at = 64'h1; bad_at = 64'h1; exp_n = 0; bp = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 req_ready after reset", 64'(req_ready), 64'd1);
        chk("R10 idle outputs after reset", {61'd0, seg_valid, rd_valid, done}, 64'd0);
    endtask

    task automatic t_single();
        reset_model();
        add(64'h1000_0100, 32'h200);
        run(64'h1000_0100, 64'h0, 32'h200, 2'd0);
        chk("R2 single segment", 64'(mism), 0);
        chk("R2 seg count", 64'(seg_n), 1);
        chk("R10 no err on success", 64'(err_seen), 0);
    endtask

    task automatic t_two_pages();
        reset_model();
        add(64'h2000_0F00, 32'h100);
        add(64'h3000_0000, 32'h1000);
        run(64'h2000_0F00, 64'h3000_0000, 32'h1100, 2'd0);
        chk("R5 two segments", 64'(mism), 0);
        chk("R5 seg count", 64'(seg_n), 2);
        chk("R5 no read issued", 64'(rd_n), 0);
        reset_model();
        add(64'h2000_1F00, 32'h100);
        add(64'h3000_2000, 32'h2000);
        run(64'h2000_1F00, 64'h3000_2000, 32'h2100, 2'd1);
        chk("R1 8K page boundary", 64'(mism), 0);
        chk("R1 seg count", 64'(seg_n), 2);
        chk("R1 no err", 64'(err_seen), 0);
    endtask

    task automatic t_errors();
        reset_model();
        run(64'h0, 64'h3000_0000, 32'h100, 2'd0);
        chk("R3 zero ptr1 err", 64'(err_seen), 1);
        chk("R3 zero ptr1 no seg", 64'(seg_n), 0);
        reset_model();
        run(64'h1000_0000, 64'h0, 32'h0, 2'd0);
        chk("R3 zero length no err", 64'(err_seen), 0);
        chk("R3 zero length no seg", 64'(seg_n), 0);
        reset_model();
        add(64'h1000_0800, 32'h800);
        run(64'h1000_0800, 64'h0, 32'h1000, 2'd0);
        chk("R4 zero ptr2 err", 64'(err_seen), 1);
        chk("R4 first seg only", 64'(seg_n), 1);
        chk("R4 first seg value", 64'(mism), 0);
        reset_model();
        add(64'h1000_0800, 32'h800);
        run(64'h1000_0800, 64'h3000_0010, 32'h1000, 2'd0);
        chk("R5 misaligned ptr2 err", 64'(err_seen), 1);
        chk("R5 misaligned ptr2 seg count", 64'(seg_n), 1);
    endtask

    task automatic t_list();
        reset_model();
        add(64'h4000_0000, 32'h1000);
        for (int i = 0; i < 3; i++) add((64'h5000_0000 + 64'(8*i)) << 12, 32'h1000);
        add((64'h5000_0000 + 64'd24) << 12, 32'h10);
        run(64'h4000_0000, 64'h5000_0000, 32'h4010, 2'd0);
        chk("R6 list segments", 64'(mism), 0);
        chk("R6 list seg count", 64'(seg_n), 5);
        chk("R6 list reads", 64'(rd_n), 4);
        chk("R6 no err", 64'(err_seen), 0);
    endtask

    task automatic t_chain();
        reset_model();
        bp = 1'b1;
        link_at = 64'h5000_0000 + 64'd4088;
        link_to = 64'h7000_0000;
        add(64'h6000_0800, 32'h800);
        for (int i = 0; i < 511; i++) add((64'h5000_0000 + 64'(8*i)) << 12, 32'h1000);
        add(64'h7000_0000 << 12, 32'h1000);
        add(64'h7000_0008 << 12, 32'h1000);
        run(64'h6000_0800, 64'h5000_0000, 32'h800 + 32'd513 * 32'h1000, 2'd0);
        chk("R7 chained segments under backpressure R9", 64'(mism), 0);
        chk("R7 chained seg count", 64'(seg_n), 514);
        chk("R7 chained reads", 64'(rd_n), 514);
        chk("R7 no err", 64'(err_seen), 0);
    endtask

    task automatic t_last_slot_data();
        reset_model();
        link_at = 64'h5000_0000 + 64'd4088;
        link_to = 64'h7000_0000;
        add(64'h6000_0800, 32'h800);
        for (int i = 0; i < 511; i++) add((64'h5000_0000 + 64'(8*i)) << 12, 32'h1000);
        add(64'h7000_0000, 32'h1000);
        run(64'h6000_0800, 64'h5000_0000, 32'h800 + 32'd512 * 32'h1000, 2'd0);
        chk("R7 last slot as data", 64'(mism), 0);
        chk("R7 last slot seg count", 64'(seg_n), 513);
        chk("R7 last slot reads", 64'(rd_n), 512);
    endtask

    task automatic t_bad_entry();
        reset_model();
        bad_at = 64'h5000_0008;
        bad_val = 64'h5000_0123;
        add(64'h4000_0000, 32'h1000);
        add(64'h5000_0000 << 12, 32'h1000);
        run(64'h4000_0000, 64'h5000_0000, 32'h4010, 2'd0);
        chk("R8 misaligned entry err", 64'(err_seen), 1);
        chk("R8 segs before abort", 64'(seg_n), 2);
        chk("R8 no read after abort", 64'(rd_n), 2);
        chk("R8 seg values", 64'(mism), 0);
        reset_model();
        bad_at = 64'h5000_0000;
        bad_val = 64'h0;
        add(64'h4000_0000, 32'h1000);
        run(64'h4000_0000, 64'h5000_0000, 32'h4010, 2'd0);
        chk("R8 zero entry err", 64'(err_seen), 1);
        chk("R8 zero entry seg count", 64'(seg_n), 1);
        reset_model();
        link_at = 64'h5000_0000 + 64'd4088;
        link_to = 64'h7000_0004;
        run(64'h6000_0800, 64'h5000_0000, 32'h800 + 32'd513 * 32'h1000, 2'd0);
        chk("R8 bad link err", 64'(err_seen), 1);
        chk("R8 bad link seg count", 64'(seg_n), 512);
        chk("R8 bad link reads", 64'(rd_n), 512);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_two_pages();
        t_errors();
        t_list();
        t_chain();
        t_last_slot_data();
        t_bad_entry();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired act=%0d exp<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule